// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block collects two kinds of event, a finished command and an arrival on the message channel. Each event sets its own sticky bit in a status register. A separate enable register gates those bits. Software reaches both registers through a simple 32-bit register port. Every access is a full 4-byte word with byte 0 in bits 7:0. The status register is write-one-to-clear. A write to the enable register replaces its whole value.

The result has two possible outputs. In the default mode it drives a level interrupt line that stays high while any enabled status bit is set. When message-signalled mode is selected, the level line is held low. Instead, the block emits a one-cycle notify pulse after each update (an event, a status write or an enable write) that leaves an enabled bit set.

The block also helps with completions that are not yet processed. After every status write it raises a one-cycle retry request if the completion-pending input was high, so that completion processing starts again.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset the status and enable registers read 0, and irqLevel, msiNotify and retryReq are low.
- R2: A pulse on cmplEvt sets status bit 0, and a pulse on msgEvt sets status bit 1. The new value is visible from the cycle after the event. Other status bits are never set.
- R3: A write to offset 0x0 (status) clears each status bit written as 1. Bits written as 0 keep their value.
- R4: A write to offset 0x4 (enable) replaces all 32 enable bits with the written data.
- R5: If an event and a status write that clears the same bit fall in the same cycle, the bit ends up set. Other bits in the write are still cleared.
- R6: With msiEnable low, irqLevel is high exactly when (status & enable) is nonzero.
- R7: With msiEnable high, irqLevel stays low. msiNotify is high for one cycle after each update whose resulting (status & enable) is nonzero, and stays low after an update whose result is zero.
- R8: retryReq is high for exactly the one cycle after a status write, and only if cmplPending was high in the cycle of that write.
- R9: Reads of offset 0x0 and 0x4 return the current status and enable values. Reads of any other offset return 0. Writes to any other offset change nothing.
- R10: msiNotify never rises in a cycle that follows no update, even when the gated status is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W (4) | Byte offset of the register access |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| cmplEvt | input | 1 | Completion event pulse |
| msgEvt | input | 1 | Message event pulse |
| cmplPending | input | 1 | Completions still wait to be processed |
| msiEnable | input | 1 | Selects message-signalled notification |
| irqLevel | output | 1 | Level interrupt line |
| msiNotify | output | 1 | One-cycle message-signalled notify pulse |
| retryReq | output | 1 | One-cycle request to restart completion processing |

## Verification
The hardest case to reach from the ports is an event and a clearing status write that land on the same bit in the same clock. The stimulus task can therefore drive an event strobe and a register write together in one cycle. The message-signalled path needs updates that leave the gated status at zero as well as updates that leave it nonzero. It also needs an idle cycle with a live gated status. The sequence therefore turns the mode on while status is already pending, then writes the enable register to zero and to nonzero values.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int DATA_W   = 32;
  localparam int CMPL_BIT = 0;
  localparam int MSG_BIT  = 1;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_STATUS = 2'd1,
    RD_ENABLE = 2'd2
  } rd_sel_e;

  typedef struct packed {
    logic    wrStatus;
    logic    wrEnable;
    logic    setCmpl;
    logic    setMsg;
    logic    update;
    rd_sel_e rdSel;
  } irq_strobe_t;
endpackage

// File: rtl/evt_irq_ctrl_fsm.sv
module evt_irq_ctrl_fsm
  import evt_irq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] STATUS_OFS = 'h0,
  parameter logic [ADDR_W-1:0] ENABLE_OFS = 'h4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              cmplEvt,
  input  logic              msgEvt,
  output irq_strobe_t       stb
);
  logic hitStatus;
  logic hitEnable;

  assign hitStatus = (regAddr == STATUS_OFS);
  assign hitEnable = (regAddr == ENABLE_OFS);

  always_comb begin
    stb          = '0;
    stb.wrStatus = regWrEn && hitStatus;
    stb.wrEnable = regWrEn && hitEnable;
    stb.setCmpl  = cmplEvt;
    stb.setMsg   = msgEvt;
    stb.update   = stb.wrStatus || stb.wrEnable || cmplEvt || msgEvt;
    if (hitStatus)      stb.rdSel = RD_STATUS;
    else if (hitEnable) stb.rdSel = RD_ENABLE;
    else                stb.rdSel = RD_NONE;
  end

  // Every event must reach the datapath as an update.
  assert_event_updates_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmplEvt || msgEvt) |-> stb.update);

  // An access to an unmapped offset raises no write strobe.
  assert_unmapped_write_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr != STATUS_OFS && regAddr != ENABLE_OFS) |-> !(stb.wrStatus || stb.wrEnable));
endmodule

// File: rtl/evt_irq_ctrl_dp.sv
module evt_irq_ctrl_dp
  import evt_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  irq_strobe_t       stb,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              cmplPending,
  input  logic              msiEnable,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqLevel,
  output logic              msiNotify,
  output logic              retryReq
);
  logic [DATA_W-1:0] statusQ, statusNext;
  logic [DATA_W-1:0] enableQ, enableNext;
  logic [DATA_W-1:0] clrMask;
  logic              gatedNext;
  logic              notifyQ;
  logic              retryQ;

  assign clrMask = stb.wrStatus ? regWrData : '0;

  for (genvar i = 0; i < DATA_W; i++) begin : g_stat
    if (i == CMPL_BIT) begin : g_cmpl
      assign statusNext[i] = (statusQ[i] & ~clrMask[i]) | stb.setCmpl;
    end else if (i == MSG_BIT) begin : g_msg
      assign statusNext[i] = (statusQ[i] & ~clrMask[i]) | stb.setMsg;
    end else begin : g_plain
      assign statusNext[i] = statusQ[i] & ~clrMask[i];
    end
  end

  assign enableNext = stb.wrEnable ? regWrData : enableQ;
  assign gatedNext  = |(statusNext & enableNext);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      enableQ <= '0;
      notifyQ <= 1'b0;
      retryQ  <= 1'b0;
    end else begin
      statusQ <= statusNext;
      enableQ <= enableNext;
      notifyQ <= stb.update && msiEnable && gatedNext;
      retryQ  <= stb.wrStatus && cmplPending;
    end
  end

  always_comb begin
    unique case (stb.rdSel)
      RD_STATUS: regRdData = statusQ;
      RD_ENABLE: regRdData = enableQ;
      default:   regRdData = '0;
    endcase
  end

  assign irqLevel  = !msiEnable && |(statusQ & enableQ);
  assign msiNotify = notifyQ;
  assign retryReq  = retryQ;

  assert_cmpl_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.setCmpl |=> statusQ[CMPL_BIT]);

  assert_msg_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.setMsg |=> statusQ[MSG_BIT]);

  assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrStatus && !stb.setCmpl && !stb.setMsg) |=> ((statusQ & $past(regWrData)) == '0));

  assert_enable_replaced_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrEnable |=> (enableQ == $past(regWrData)));

  assert_level_follows_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.setCmpl && !stb.wrEnable && enableQ[CMPL_BIT] && !msiEnable) |=> (irqLevel || msiEnable));

  assert_msi_quiet_level_R7: assert property (@(posedge clk) disable iff (!rstN)
    msiEnable |-> !irqLevel);

  assert_retry_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrStatus |=> (retryReq == $past(cmplPending)));

  assert_no_write_no_retry_R8: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrStatus |=> !retryReq);

  assert_status_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.wrStatus && !stb.setCmpl && !stb.setMsg) |=> $stable(statusQ));

  assert_notify_needs_update_R10: assert property (@(posedge clk) disable iff (!rstN)
    !stb.update |=> !msiNotify);
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] STATUS_OFS = 'h0,
  parameter logic [ADDR_W-1:0] ENABLE_OFS = 'h4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              cmplEvt,
  input  logic              msgEvt,
  input  logic              cmplPending,
  input  logic              msiEnable,
  output logic              irqLevel,
  output logic              msiNotify,
  output logic              retryReq
);
  irq_strobe_t stb;

  evt_irq_ctrl_fsm #(
    .ADDR_W    (ADDR_W),
    .STATUS_OFS(STATUS_OFS),
    .ENABLE_OFS(ENABLE_OFS)
  ) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .regWrEn(regWrEn),
    .regAddr(regAddr),
    .cmplEvt(cmplEvt),
    .msgEvt (msgEvt),
    .stb    (stb)
  );

  evt_irq_ctrl_dp dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .regWrData  (regWrData),
    .cmplPending(cmplPending),
    .msiEnable  (msiEnable),
    .regRdData  (regRdData),
    .irqLevel   (irqLevel),
    .msiNotify  (msiNotify),
    .retryReq   (retryReq)
  );
endmodule

// File: tb/evt_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module evt_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        cmplEvt = 1'b0;
  logic        msgEvt = 1'b0;
  logic        cmplPending = 1'b0;
  logic        msiEnable = 1'b0;
  logic        irqLevel, msiNotify, retryReq;

  always #2.5 clk = ~clk;

  evt_irq_ctrl dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .cmplEvt(cmplEvt),
    .msgEvt(msgEvt), .cmplPending(cmplPending), .msiEnable(msiEnable),
    .irqLevel(irqLevel), .msiNotify(msiNotify), .retryReq(retryReq)
  );

  typedef struct {
    string       req;
    bit          isRead;
    logic [31:0] expData;
    logic        expLevel;
    logic        expNotify;
    logic        expRetry;
  } exp_t;

  exp_t expQ[$];
  event sampleEv;
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;

  logic [31:0] mStatus = '0;
  logic [31:0] mEnable = '0;

  task automatic cmpBit(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected items and compares with the outputs.
  initial begin
    forever begin
      @(sampleEv);
      while (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        if (e.isRead) begin
          checks++;
          if (regRdData !== e.expData) begin
            failures++;
            $display("FAIL %s read actual=%08h expected=%08h", e.req, regRdData, e.expData);
          end
        end else begin
          cmpBit(e.req, "irqLevel", irqLevel, e.expLevel);
          cmpBit(e.req, "msiNotify", msiNotify, e.expNotify);
          cmpBit(e.req, "retryReq", retryReq, e.expRetry);
        end
      end
    end
  end

  // Driver: one clock of stimulus, then expected outputs pushed for the monitor.
  task automatic step(string req, bit wr, logic [3:0] addr, logic [31:0] data,
                      bit cmpl, bit msg, bit pend);
    exp_t e;
    bit   wrS, wrE, upd;
    @(negedge clk);
    regWrEn = wr; regAddr = addr; regWrData = data;
    cmplEvt = cmpl; msgEvt = msg; cmplPending = pend;
    @(posedge clk);
    #1;
    regWrEn = 1'b0; cmplEvt = 1'b0; msgEvt = 1'b0; cmplPending = 1'b0;
    wrS = wr && (addr == 4'h0);
    wrE = wr && (addr == 4'h4);
    upd = wrS || wrE || cmpl || msg;
    mStatus = (mStatus & ~(wrS ? data : 32'h0)) | {30'h0, msg, cmpl};
    if (wrE) mEnable = data;
    e.req       = req;
    e.isRead    = 1'b0;
    e.expData   = '0;
    e.expLevel  = !msiEnable && ((mStatus & mEnable) != 0);
    e.expNotify = msiEnable && upd && ((mStatus & mEnable) != 0);
    e.expRetry  = wrS && pend;
    expQ.push_back(e);
    ->sampleEv;
    #0.5;
  endtask

  task automatic idle(string req);
    step(req, 1'b0, 4'h0, 32'h0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic readReg(string req, logic [3:0] addr);
    exp_t e;
    regAddr = addr;
    #0.2;
    e.req      = req;
    e.isRead   = 1'b1;
    e.expData  = (addr == 4'h0) ? mStatus : (addr == 4'h4) ? mEnable : 32'h0;
    e.expLevel = 1'b0; e.expNotify = 1'b0; e.expRetry = 1'b0;
    expQ.push_back(e);
    ->sampleEv;
    #0.2;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 20000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    begin
      exp_t e;
      e.req = "R1"; e.isRead = 1'b0; e.expData = '0;
      e.expLevel = 1'b0; e.expNotify = 1'b0; e.expRetry = 1'b0;
      expQ.push_back(e);
      ->sampleEv;
      #0.2;
    end
    readReg("R1", 4'h0);
    readReg("R1", 4'h4);

    step("R4", 1'b1, 4'h4, 32'h0000_0003, 1'b0, 1'b0, 1'b0);
    readReg("R4", 4'h4);
    step("R2/R6 cmpl", 1'b0, 4'h0, 32'h0, 1'b1, 1'b0, 1'b0);
    readReg("R2", 4'h0);
    step("R2/R6 msg", 1'b0, 4'h0, 32'h0, 1'b0, 1'b1, 1'b0);
    readReg("R2", 4'h0);
    step("R3/R8 clear", 1'b1, 4'h0, 32'h0000_0001, 1'b0, 1'b0, 1'b1);
    readReg("R3", 4'h0);
    step("R3/R8 zero write", 1'b1, 4'h0, 32'h0, 1'b0, 1'b0, 1'b0);
    readReg("R3", 4'h0);
    step("R4/R6 mask off", 1'b1, 4'h4, 32'h0000_0001, 1'b0, 1'b0, 1'b0);
    step("R4/R6 all on", 1'b1, 4'h4, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0);
    readReg("R4", 4'h4);
    step("R5 collide", 1'b1, 4'h0, 32'h0000_0003, 1'b1, 1'b0, 1'b0);
    readReg("R5", 4'h0);
    step("R9 unmapped", 1'b1, 4'h8, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1);
    readReg("R9", 4'h8);
    readReg("R9", 4'h0);
    readReg("R9", 4'h4);

    @(negedge clk);
    msiEnable = 1'b1;
    idle("R10 mode on");
    step("R7 msg", 1'b0, 4'h0, 32'h0, 1'b0, 1'b1, 1'b0);
    idle("R10 idle");
    step("R7 gated zero", 1'b1, 4'h4, 32'h0, 1'b0, 1'b0, 1'b0);
    step("R7 gated one", 1'b1, 4'h4, 32'h0000_0002, 1'b0, 1'b0, 1'b0);
    step("R7/R8 clear all", 1'b1, 4'h0, 32'h0000_0003, 1'b0, 1'b0, 1'b1);
    readReg("R3", 4'h0);
    idle("R8 after");

    repeat (2) @(posedge clk);
    finishRun();
  end
endmodule